// File: doc/BRIEF.md
# Threshold-Interrupt Byte Receive Queue

This block sits between an incoming byte stream from a port and the processor that consumes it. It holds up to eight bytes in arrival order and raises three independent interrupt indications: one for every byte taken in, one when the stored count climbs from three to four, and one when the queue fills. The processor can therefore wait for a half-full or full queue before servicing the port, instead of reacting to every single byte.

The input side is a valid/ready stream. `in_ready` reports free space, but the port side cannot stall. A byte offered while `in_ready` is low is discarded and a sticky overrun flag records the loss. The output side is a valid/ready stream too. `out_valid` is high whenever a byte is held, and a transfer (`out_valid && out_ready`) removes the oldest byte. `level` shows the occupancy at all times. Each interrupt source has an enable input and a sticky pending flag. A one-cycle pulse on the matching `irq_clear` bit clears the flag.

Top module: `byte_rx_queue`

## Requirements
- R1: After reset, `level` is 0, `out_valid` is 0, `in_ready` is 1, and `irq_pending`, `irq_req` and `overrun` are all 0.
- R2: Bytes leave in the order they were accepted. `out_data` shows the oldest held byte whenever `out_valid` is 1, and `out_valid` is 1 exactly when `level` is not 0.
- R3: `level` stays within 0 to 8. It updates on the clock edge after the transfer. An accepted push alone adds 1, a pop alone subtracts 1, and a push with a pop in the same cycle leaves it unchanged. `out_ready` while empty has no effect.
- R4: `in_ready` is 1 exactly when `level` is below 8. A byte offered while full is dropped even if a pop happens in the same cycle. At the next edge `overrun` becomes 1 and stays 1.
- R5: Pending bit 0 (byte source) sets on the edge after any accepted byte.
- R6: Pending bit 1 (fourth-byte source) sets only when `level` goes from 3 to 4. A cycle that leaves `level` at 4 or above does not set it.
- R7: Pending bit 2 (full source) sets when `level` goes from 7 to 8.
- R8: Pending bits are sticky. A 1 on `irq_clear[i]` for one cycle clears bit i, but a set event in the same cycle wins. A pulse on `overrun_clear` clears `overrun`, and a new drop in the same cycle wins.
- R9: `irq_req[i]` equals `irq_pending[i] & irq_enable[i]`. Pending bits set whatever the enable value is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Port side offers a byte |
| in_ready | output | 1 | Space is available (advisory; the port does not wait) |
| in_data | input | 8 | Incoming byte |
| out_valid | output | 1 | At least one byte held |
| out_ready | input | 1 | Processor takes the head byte |
| out_data | output | 8 | Oldest held byte |
| level | output | 4 | Occupancy, 0 to 8 |
| irq_enable | input | 3 | Per-source enables: bit 0 byte, bit 1 fourth byte, bit 2 full |
| irq_clear | input | 3 | Per-source clear pulses, same bit order |
| irq_pending | output | 3 | Sticky pending flags, same bit order |
| irq_req | output | 3 | Enabled pending flags |
| overrun | output | 1 | Sticky flag: a byte was dropped |
| overrun_clear | input | 1 | Clears `overrun` |

## Verification
The hardest conditions to reach from the ports are two: a push together with a pop while the queue sits exactly at four, and a push together with a pop while it is full. The first must not retrigger the fourth-byte source. In the second, the byte must be lost although a slot frees in the same cycle. The stimulus first fills the queue to these exact levels with single pushes, then drives both strobes in one cycle. It then drains the queue against a reference list of the accepted bytes, which shows that the dropped bytes never entered.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int IRQ_N = 3;
  typedef enum int {
    SRC_BYTE = 0,
    SRC_MID  = 1,
    SRC_FULL = 2
  } irq_src_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] slots [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
    end
  end

  assign rd_data = slots[rd_ptr];
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH     = 8,
  parameter int MID_LEVEL = 4,
  parameter int LW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          pop_ok,
  output logic [LW-1:0] level,
  output logic          ev_mid,
  output logic          ev_full
);
  localparam logic [LW-1:0] BELOW_MID  = LW'(MID_LEVEL - 1);
  localparam logic [LW-1:0] BELOW_FULL = LW'(DEPTH - 1);

  logic grow, shrink;
  assign grow   = push_ok && !pop_ok;
  assign shrink = pop_ok && !push_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (grow)   level <= level + 1'b1;
    else if (shrink) level <= level - 1'b1;
  end

  assign ev_mid  = grow && (level == BELOW_MID);
  assign ev_full = grow && (level == BELOW_FULL);
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int N = rxq_pkg::IRQ_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] pend,
  output logic [N-1:0] req
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend[i] <= 1'b0;
      else if (set_ev[i]) pend[i] <= 1'b1;
      else if (clr[i])    pend[i] <= 1'b0;
    end
    assign req[i] = pend[i] & en[i];
  end
endmodule

// File: rtl/byte_rx_queue.sv
module byte_rx_queue #(
  parameter int DW        = 8,
  parameter int DEPTH     = 8,
  parameter int MID_LEVEL = 4,
  parameter int LW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [LW-1:0] level,
  input  logic [2:0]    irq_enable,
  input  logic [2:0]    irq_clear,
  output logic [2:0]    irq_pending,
  output logic [2:0]    irq_req,
  output logic          overrun,
  input  logic          overrun_clear
);
  import rxq_pkg::*;

  logic full, push_ok, pop_ok, dropped, ev_mid, ev_full;
  logic [IRQ_N-1:0] events;

  assign full      = (level == LW'(DEPTH));
  assign in_ready  = !full;
  assign out_valid = (level != '0);
  assign push_ok   = in_valid && !full;
  assign pop_ok    = out_ready && out_valid;
  assign dropped   = in_valid && full;

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_data(in_data),
    .rd_en(pop_ok), .rd_data(out_data)
  );

  rxq_level #(.DEPTH(DEPTH), .MID_LEVEL(MID_LEVEL), .LW(LW)) u_level (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
    .level(level), .ev_mid(ev_mid), .ev_full(ev_full)
  );

  always_comb begin
    events           = '0;
    events[SRC_BYTE] = push_ok;
    events[SRC_MID]  = ev_mid;
    events[SRC_FULL] = ev_full;
  end

  rxq_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_ev(events), .clr(irq_clear),
    .en(irq_enable), .pend(irq_pending), .req(irq_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             overrun <= 1'b0;
    else if (dropped)       overrun <= 1'b1;
    else if (overrun_clear) overrun <= 1'b0;
  end
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH     = 8,
  parameter int MID_LEVEL = 4,
  parameter int LW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [LW-1:0] level,
  input logic [2:0]    irq_enable,
  input logic [2:0]    irq_pending,
  input logic [2:0]    irq_req,
  input logic          overrun
);
  assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(out_ready && out_valid)) |=> level == $past(level) + 1'b1);

  assert_empty_pop_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && !in_valid) |=> level == '0);

  assert_valid_tracks_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (level != '0));

  assert_ready_tracks_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (level < LW'(DEPTH)));

  assert_drop_sets_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overrun);

  assert_full_no_growth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LW'(DEPTH) && !out_ready) |=> level == LW'(DEPTH));

  assert_byte_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> irq_pending[0]);

  assert_mid_only_on_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending[1]) |-> (level == LW'(MID_LEVEL) && $past(level) == LW'(MID_LEVEL - 1)));

  assert_full_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending[2]) |-> level == LW'(DEPTH));

  assert_req_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (irq_pending & irq_enable));
endmodule

bind byte_rx_queue rxq_checker #(.DEPTH(DEPTH), .MID_LEVEL(MID_LEVEL), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .level(level),
  .irq_enable(irq_enable), .irq_pending(irq_pending), .irq_req(irq_req),
  .overrun(overrun)
);

// File: tb/byte_rx_queue_tb.sv
`timescale 1ns/1ps
module byte_rx_queue_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, overrun_clear = 1'b0;
  logic [7:0] in_data = '0;
  logic [2:0] irq_enable = '0, irq_clear = '0;
  logic in_ready, out_valid, overrun;
  logic [7:0] out_data;
  logic [3:0] level;
  logic [2:0] irq_pending, irq_req;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mq[$];

  always #2 clk = ~clk;

  byte_rx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .level(level), .irq_enable(irq_enable),
    .irq_clear(irq_clear), .irq_pending(irq_pending), .irq_req(irq_req),
    .overrun(overrun), .overrun_clear(overrun_clear)
  );

  // vector: [21] push, [20] pop, [19:12] data, [11:8] level after, [7:0] head after
  localparam logic [21:0] VEC [13] = '{
    {1'b1, 1'b0, 8'hA1, 4'd1, 8'hA1},
    {1'b1, 1'b0, 8'hA2, 4'd2, 8'hA1},
    {1'b1, 1'b1, 8'hA3, 4'd2, 8'hA2},
    {1'b0, 1'b1, 8'h00, 4'd1, 8'hA3},
    {1'b1, 1'b0, 8'hB0, 4'd2, 8'hA3},
    {1'b1, 1'b0, 8'hB1, 4'd3, 8'hA3},
    {1'b1, 1'b0, 8'hB2, 4'd4, 8'hA3},
    {1'b1, 1'b1, 8'hB3, 4'd4, 8'hB0},
    {1'b0, 1'b1, 8'h00, 4'd3, 8'hB1},
    {1'b0, 1'b1, 8'h00, 4'd2, 8'hB2},
    {1'b0, 1'b1, 8'h00, 4'd1, 8'hB3},
    {1'b0, 1'b1, 8'h00, 4'd0, 8'h00},
    {1'b0, 1'b1, 8'h00, 4'd0, 8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs settled
  task automatic step(input logic p, input logic q, input logic [7:0] d,
                      input logic [2:0] clr, input logic oc);
    in_valid = p; out_ready = q; in_data = d; irq_clear = clr; overrun_clear = oc;
    @(negedge clk);
    in_valid = 0; out_ready = 0; irq_clear = '0; overrun_clear = 0;
  endtask

  task automatic push(input logic [7:0] d);
    if (level < 4'd8) mq.push_back(d);
    step(1, 0, d, 3'b000, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 level", level, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);
    check("R1 pending", irq_pending, 0);
    check("R1 req", irq_req, 0);
    check("R1 overrun", overrun, 0);
    rst_n = 1;
    @(negedge clk);

    // table walk: R2 ordering, R3 level arithmetic
    foreach (VEC[i]) begin
      step(VEC[i][21], VEC[i][20], VEC[i][19:12], 3'b000, 0);
      check("R3 level", level, VEC[i][11:8]);
      check("R2 out_valid", out_valid, VEC[i][11:8] != 0);
      if (VEC[i][11:8] != 0) check("R2 head", out_data, VEC[i][7:0]);
    end

    // clear everything; R8
    step(0, 0, 8'h00, 3'b111, 0);
    check("R8 cleared", irq_pending, 0);

    // R9: pending sets with enable off; req follows enable
    push(8'hC0);
    check("R5 byte pending", irq_pending[0], 1);
    check("R9 req gated", irq_req, 0);
    irq_enable = 3'b111;
    #0.1;
    check("R9 req enabled", irq_req, 3'b001);
    // R8 set wins over clear
    mq.push_back(8'hC1);
    step(1, 0, 8'hC1, 3'b001, 0);
    check("R8 set wins", irq_pending[0], 1);
    step(0, 0, 8'h00, 3'b001, 0);
    check("R8 clear", irq_pending[0], 0);

    // R6 fourth-byte source
    push(8'hC2);
    check("R6 at three", irq_pending[1], 0);
    push(8'hC3);
    check("R6 level", level, 4);
    check("R6 set on 3->4", irq_pending[1], 1);
    step(0, 0, 8'h00, 3'b010, 0);
    mq.push_back(8'hC4); void'(mq.pop_front());
    step(1, 1, 8'hC4, 3'b000, 0);
    check("R3 push+pop level", level, 4);
    check("R6 no retrigger", irq_pending[1], 0);

    // R7 full source and R4 overrun
    push(8'hC5); push(8'hC6); push(8'hC7);
    check("R7 at seven", irq_pending[2], 0);
    push(8'hC8);
    check("R7 full pending", irq_pending[2], 1);
    check("R4 in_ready full", in_ready, 0);
    step(1, 0, 8'hEE, 3'b000, 0);
    check("R4 drop level", level, 8);
    check("R4 overrun", overrun, 1);
    void'(mq.pop_front());
    step(1, 1, 8'hEF, 3'b000, 0);
    check("R4 drop with pop", level, 7);
    check("R4 overrun sticky", overrun, 1);
    step(0, 0, 8'h00, 3'b000, 1);
    check("R8 overrun clear", overrun, 0);

    // drain: R2 order, dropped bytes absent
    while (mq.size() > 0) begin
      check("R2 drain head", out_data, mq[0]);
      void'(mq.pop_front());
      step(0, 1, 8'h00, 3'b000, 0);
    end
    check("R3 drained", level, 0);
    check("R2 empty", out_valid, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule